// File: doc/BRIEF.md
# Bus Acknowledge and Strobe Watchdog

This block closes every processor bus cycle. It merges the acknowledges of four address-decoded devices into one active-low transfer acknowledge: a static RAM, a read-only memory, a serial controller and a write-only output latch. Two devices answer at once. The serial controller drives its own acknowledge, which passes straight through. The read-only memory is slow, so a shift register clocked by the system clock holds back its acknowledge by a set number of clock edges.

A second shift register watches the address strobe. It advances only on a slow periodic tick and raises an active-low bus error when the strobe stays low for too many ticks. A cycle that no device acknowledges therefore ends in a bus error rather than a hang. Such a cycle is a read of the write-only latch, a write to the read-only memory, or an address with no device behind it.

The tick enable comes from outside the block. Its source is expected to pulse for one clock once every ten system clocks. The address decoder sits upstream of this block and supplies the selects.

Top module: `bus_ack_unit`

## Requirements
- R1: After a synchronous active-high reset, with no select and no serial acknowledge active, `dtack_n` and `berr_n` are both high (1 = idle).
- R2: While `ram_sel_n` is low, `dtack_n` is low in the same cycle, with no wait state.
- R3: The output latch is acknowledged at once on a write (`rw` = 0). A read of it (`rw` = 1) yields no acknowledge.
- R4: The serial controller's `uart_ack_n` appears on `dtack_n` unchanged and in the same cycle.
- R5: A ROM read cycle has `as_n` low, `rom_sel_n` low and `rw` = 1. For such a cycle, `dtack_n` goes low after exactly ROM_TAP rising clock edges (default 2) and not before.
- R6: Whenever the ROM read qualification drops, the ROM wait register clears. This happens when the strobe goes high or the select is removed. The next ROM read then waits the full ROM_TAP edges again.
- R7: A write cycle to the ROM (`rw` = 0) produces no acknowledge.
- R8: With `as_n` held low, `berr_n` goes low on the clock edge that samples the TO_STAGES-th `tick_en` pulse (default 4), and stays high before it.
- R9: While `as_n` is high, `berr_n` is high and the timeout register is clear. A new strobe starts the full count again.
- R10: An access with no device selected and no serial acknowledge gives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Slow timeout tick, one clock wide |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| ram_sel_n | input | 1 | RAM select, active low |
| rom_sel_n | input | 1 | ROM select, active low |
| uart_sel_n | input | 1 | Serial controller select, active low |
| par_sel_n | input | 1 | Output latch select, active low |
| uart_ack_n | input | 1 | Serial controller acknowledge, active low |
| dtack_n | output | 1 | Merged transfer acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |

## Verification
The bench uses the default parameters: a tap at stage 2 of a 4-stage wait register, and 4 timeout stages. It drives a tick every ten clocks. With these values a complete timeout takes about forty clocks, so the bench can observe every unacknowledged cycle running all the way to bus error. This includes a read of the output latch, a ROM write and an empty address. The short tap also allows a ROM read that is interrupted one edge early, which shows that the wait count restarts from zero on the next read.

// File: rtl/bus_ack_pkg.sv
package bus_ack_pkg;

    // Active-high view of the device selects
    typedef struct packed {
        logic ram;
        logic rom;
        logic uart;
        logic par;
    } dev_sel_t;

    // Individual acknowledges, active high
    typedef struct packed {
        logic ram;
        logic rom;
        logic uart;
        logic par;
    } dev_ack_t;

    typedef enum logic {
        XFER_WRITE = 1'b0,
        XFER_READ  = 1'b1
    } xfer_dir_t;

    function automatic dev_sel_t decode_sel(input logic ram_n, input logic rom_n,
                                            input logic uart_n, input logic par_n);
        dev_sel_t s;
        s.ram  = ~ram_n;
        s.rom  = ~rom_n;
        s.uart = ~uart_n;
        s.par  = ~par_n;
        return s;
    endfunction

    function automatic logic any_ack(input dev_ack_t a);
        return a.ram | a.rom | a.uart | a.par;
    endfunction

endpackage

// File: rtl/bus_ack_shift.sv
module bus_ack_shift #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_clr,
    input  logic              step,
    output logic [STAGES-1:0] stages
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || hold_clr) sr_q <= '0;
                else if (step)       sr_q <= 1'b1;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst || hold_clr) sr_q <= '0;
                else if (step)       sr_q <= {sr_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign stages = sr_q;
endmodule

// File: rtl/bus_ack_merge.sv
module bus_ack_merge
    import bus_ack_pkg::*;
(
    input  dev_sel_t  sel,
    input  xfer_dir_t dir,
    input  logic      rom_ready,
    input  logic      uart_ack,
    output logic      dtack_n
);
    dev_ack_t acks;

    always_comb begin
        acks.ram  = sel.ram;
        acks.par  = sel.par && (dir == XFER_WRITE);
        acks.rom  = rom_ready;
        acks.uart = uart_ack;
        dtack_n   = ~any_ack(acks);
    end
endmodule

// File: rtl/bus_ack_unit.sv
module bus_ack_unit
    import bus_ack_pkg::*;
#(
    parameter int WAIT_STAGES = 4,
    parameter int ROM_TAP     = 2,
    parameter int TO_STAGES   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic as_n,
    input  logic rw,
    input  logic ram_sel_n,
    input  logic rom_sel_n,
    input  logic uart_sel_n,
    input  logic par_sel_n,
    input  logic uart_ack_n,
    output logic dtack_n,
    output logic berr_n
);
    localparam int TAP_IDX = ROM_TAP - 1;
    localparam int TO_IDX  = TO_STAGES - 1;

    dev_sel_t  sel;
    xfer_dir_t dir;
    logic      rom_rd;
    logic [WAIT_STAGES-1:0] wait_q;
    logic [TO_STAGES-1:0]   to_q;
    logic      rom_ready;

    assign sel    = decode_sel(ram_sel_n, rom_sel_n, uart_sel_n, par_sel_n);
    assign dir    = xfer_dir_t'(rw);
    assign rom_rd = ~as_n && sel.rom && (dir == XFER_READ);

    bus_ack_shift #(.STAGES(WAIT_STAGES)) u_rom_wait (
        .clk      (clk),
        .rst      (rst),
        .hold_clr (~rom_rd),
        .step     (1'b1),
        .stages   (wait_q)
    );

    bus_ack_shift #(.STAGES(TO_STAGES)) u_strobe_to (
        .clk      (clk),
        .rst      (rst),
        .hold_clr (as_n),
        .step     (tick_en),
        .stages   (to_q)
    );

    // Qualified by the live condition so a dropped strobe clears at once
    assign rom_ready = wait_q[TAP_IDX] && rom_rd;
    assign berr_n    = ~(to_q[TO_IDX] && ~as_n);

    bus_ack_merge u_merge (
        .sel      (sel),
        .dir      (dir),
        .rom_ready(rom_ready),
        .uart_ack (~uart_ack_n),
        .dtack_n  (dtack_n)
    );
endmodule

// File: rtl/bus_ack_checker.sv
module bus_ack_checker (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic as_n,
    input logic rw,
    input logic ram_sel_n,
    input logic rom_sel_n,
    input logic par_sel_n,
    input logic uart_ack_n,
    input logic dtack_n,
    input logic berr_n
);
    logic seen_clk;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && $past(rst) && ram_sel_n && par_sel_n && uart_ack_n) |-> (dtack_n && berr_n)); // R1
    AST_RAM_ACK: assert property (@(posedge clk) disable iff (rst)
        !ram_sel_n |-> !dtack_n); // R2
    AST_PAR_READ_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!par_sel_n && rw && ram_sel_n && rom_sel_n && uart_ack_n) |-> dtack_n); // R3
    AST_UART_PASS: assert property (@(posedge clk) disable iff (rst)
        !uart_ack_n |-> !dtack_n); // R4
    AST_ROM_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && !rom_sel_n && rw && !as_n && $past(rom_sel_n)
         && ram_sel_n && par_sel_n && uart_ack_n) |-> dtack_n); // R5
    AST_ROM_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!rom_sel_n && !rw && ram_sel_n && par_sel_n && uart_ack_n) |-> dtack_n); // R7
    AST_BERR_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && $fell(berr_n)) |-> $past(tick_en)); // R8
    AST_BERR_STROBE: assert property (@(posedge clk) disable iff (rst)
        as_n |-> berr_n); // R9
    AST_NO_DEV: assert property (@(posedge clk) disable iff (rst)
        (ram_sel_n && rom_sel_n && par_sel_n && uart_ack_n) |-> dtack_n); // R10
endmodule

bind bus_ack_unit bus_ack_checker u_bus_ack_checker (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .as_n      (as_n),
    .rw        (rw),
    .ram_sel_n (ram_sel_n),
    .rom_sel_n (rom_sel_n),
    .par_sel_n (par_sel_n),
    .uart_ack_n(uart_ack_n),
    .dtack_n   (dtack_n),
    .berr_n    (berr_n)
);

// File: tb/test_bus_ack_unit.sv
module test_bus_ack_unit;
    localparam int ROM_TAP = 2;
    localparam int TO_ST   = 4;
    localparam int TICK_DIV = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic as_n = 1'b1, rw = 1'b1;
    logic ram_sel_n = 1'b1, rom_sel_n = 1'b1, uart_sel_n = 1'b1, par_sel_n = 1'b1;
    logic uart_ack_n = 1'b1;
    logic dtack_n, berr_n;

    int checks = 0, failures = 0, cycles = 0;
    int rom_cnt = 0, to_cnt = 0, tick_ctr = 0;
    string cur_req = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    bus_ack_unit i_bus_ack_unit (
        .clk(clk), .rst(rst), .tick_en(tick_en), .as_n(as_n), .rw(rw),
        .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .uart_sel_n(uart_sel_n),
        .par_sel_n(par_sel_n), .uart_ack_n(uart_ack_n),
        .dtack_n(dtack_n), .berr_n(berr_n)
    );

    // Tick generator: one clock wide, every TICK_DIV clocks
    always @(negedge clk) begin
        #2;
        tick_ctr = (tick_ctr + 1) % TICK_DIV;
        tick_en  = (tick_ctr == 0);
    end

    // Behavioural reference: elapsed counts
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            rom_cnt = 0;
            to_cnt  = 0;
        end else begin
            if (!as_n && !rom_sel_n && rw) rom_cnt = (rom_cnt < 100) ? rom_cnt + 1 : rom_cnt;
            else rom_cnt = 0;
            if (as_n) to_cnt = 0;
            else if (tick_en && to_cnt < 100) to_cnt++;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        logic rom_rd, e_dt, e_be;
        if (!rst && !done) begin
            rom_rd = !as_n && !rom_sel_n && rw;
            e_dt = !(!ram_sel_n || (!par_sel_n && !rw) || !uart_ack_n
                     || (rom_rd && rom_cnt >= ROM_TAP));
            e_be = !(!as_n && to_cnt >= TO_ST);
            check(cur_req, dtack_n, e_dt, "dtack_n model");
            check(cur_req, berr_n,  e_be, "berr_n model");
        end
    end

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        wait (cycles > 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic drive(input logic a, input logic r, input logic ram, input logic rom,
                         input logic ua, input logic par, input logic ack);
        @(negedge clk);
        #2;
        as_n = a; rw = r; ram_sel_n = ram; rom_sel_n = rom;
        uart_sel_n = ua; par_sel_n = par; uart_ack_n = ack;
    endtask

    task automatic idle();
        drive(1, 1, 1, 1, 1, 1, 1);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Wait for berr_n to fall; return cycles taken
    task automatic run_to_berr(output int n);
        n = 0;
        while (berr_n && n < 60) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #2 rst = 0;
        wait_cyc(1);
        check("R1", dtack_n, 1'b1, "dtack after reset");
        check("R1", berr_n, 1'b1, "berr after reset");

        cur_req = "R2";
        drive(0, 1, 0, 1, 1, 1, 1);
        wait_cyc(1);
        check("R2", dtack_n, 1'b0, "RAM read ack");
        idle();
        drive(0, 0, 0, 1, 1, 1, 1);
        wait_cyc(1);
        check("R2", dtack_n, 1'b0, "RAM write ack");
        idle();

        cur_req = "R3";
        drive(0, 0, 1, 1, 1, 0, 1);
        wait_cyc(1);
        check("R3", dtack_n, 1'b0, "latch write ack");
        idle();
        drive(0, 1, 1, 1, 1, 0, 1);
        wait_cyc(3);
        check("R3", dtack_n, 1'b1, "latch read no ack");
        cur_req = "R8";
        run_to_berr(n);
        check("R8", berr_n, 1'b0, "latch read ends in berr");
        check("R8", (n >= 27 && n <= 39), 1'b1, "timeout window");
        cur_req = "R9";
        idle();
        wait_cyc(1);
        check("R9", berr_n, 1'b1, "berr released with strobe");

        cur_req = "R4";
        drive(0, 1, 1, 1, 0, 1, 1);
        wait_cyc(2);
        check("R4", dtack_n, 1'b1, "uart waits for own ack");
        drive(0, 1, 1, 1, 0, 1, 0);
        wait_cyc(1);
        check("R4", dtack_n, 1'b0, "uart ack passed");
        idle();

        cur_req = "R5";
        drive(0, 1, 1, 0, 1, 1, 1);
        wait_cyc(1);
        check("R5", dtack_n, 1'b1, "ROM not after 1 edge");
        wait_cyc(1);
        check("R5", dtack_n, 1'b0, "ROM after 2 edges");
        wait_cyc(3);
        check("R5", dtack_n, 1'b0, "ROM ack held");

        cur_req = "R6";
        idle();
        drive(0, 1, 1, 0, 1, 1, 1);
        wait_cyc(1);
        idle();
        wait_cyc(1);
        check("R6", dtack_n, 1'b1, "aborted ROM no ack");
        drive(0, 1, 1, 0, 1, 1, 1);
        wait_cyc(1);
        check("R6", dtack_n, 1'b1, "ROM restarts wait");
        wait_cyc(1);
        check("R6", dtack_n, 1'b0, "ROM ack after full wait");
        idle();

        cur_req = "R7";
        drive(0, 0, 1, 0, 1, 1, 1);
        wait_cyc(6);
        check("R7", dtack_n, 1'b1, "ROM write no ack");
        cur_req = "R8";
        run_to_berr(n);
        check("R8", berr_n, 1'b0, "ROM write berr");
        idle();

        cur_req = "R10";
        drive(0, 1, 1, 1, 1, 1, 1);
        wait_cyc(5);
        check("R10", dtack_n, 1'b1, "empty address no ack");
        cur_req = "R9";
        wait_cyc(10);
        idle();
        wait_cyc(2);
        check("R9", berr_n, 1'b1, "strobe high berr idle");
        drive(0, 1, 1, 1, 1, 1, 1);
        run_to_berr(n);
        check("R9", (n >= 27 && n <= 39), 1'b1, "timeout restarts fully");
        idle();
        wait_cyc(3);
        finish_run();
    end
endmodule